// File: doc/BRIEF.md
# Target CPU Reset and Bus Ownership Controller

This block sits between a host controller and a slave CPU. It decides whether the CPU is held in reset or allowed to run. Separately, it decides whether the host owns the CPU's memory bus, which it takes and gives back through an active-low bus-request / bus-acknowledge handshake. The host issues single-cycle command pulses: reset, request, release, run, restart and machine-cycle. The block turns them into the CPU-facing reset and bus-request lines, the output enable for the address bus and control strobes, and the idle levels of the memory-request, read and write strobes. Memory access cycles themselves are done elsewhere, while this block reports ownership.

Being held in reset or running, and owning the bus or not, combine into one four-state machine. The current state is reported as a 2-bit code. Steps that wait for the acknowledge or time a pulse raise `busy`. While `busy` is high, every command except reset is dropped. A restart pulses the CPU reset while the bus stays owned. A machine-cycle command hands the bus back for a short, fixed number of clocks and then takes it again, so the CPU can make a single bus cycle.

Top module: `tgt_bus_ctrl`

## Requirements
- R1: After asynchronous reset (`rst_n` low), `state_code` is 0, `tgt_rst_n` is 0, `busreq_n` is 1, `addr_oe` and `ctl_oe` are 0, and `busy` is 0. State codes are: 0 = CPU in reset with the bus not owned, 1 = in reset-exit with the bus owned, 2 = running with the bus not owned, 3 = running with the bus owned.
- R2: A reset command takes effect one cycle later from any state, including while `busy` is high. The result is code 0, `tgt_rst_n`=0, `busreq_n`=1, both enables 0 and `busy`=0.
- R3: A request command in code 0 sets `tgt_rst_n`=1 and `busreq_n`=0 one cycle later. In code 2 it sets `busreq_n`=0 and leaves `tgt_rst_n` unchanged. In both cases `busy` goes to 1. Once the synchronised acknowledge is low, `addr_oe`/`ctl_oe` rise, `busy` falls and the code becomes 1 (from 0) or 3 (from 2), all in the same cycle.
- R4: A release command in code 1 gives code 0 one cycle later, with both enables 0, `tgt_rst_n`=0 and `busreq_n`=1. In code 3 it gives code 2, with both enables 0 and `busreq_n`=1.
- R5: A run command in code 0 gives code 2 with `tgt_rst_n`=1 one cycle later. In code 1 it drops both enables and drives `tgt_rst_n` low for exactly RST_PULSE_CYCLES cycles. When the pulse ends, it restores the enables and sets code 3.
- R6: A restart command in code 2 or 3 drives `tgt_rst_n` low for exactly RST_PULSE_CYCLES cycles. The code stays the same, and the enables keep their values throughout.
- R7: A machine-cycle command in code 3 drops both enables and drives `busreq_n` high for exactly BREQ_HOLD_CYCLES cycles, then low again. Once the synchronised acknowledge is low, the enables return and `busy` falls. The code stays 3.
- R8: `mreq_n`, `rd_n` and `wr_n` output 1 while `ctl_oe` is 1 and 0 while it is 0. `ctl_oe` always equals `addr_oe`.
- R9: A command that is not valid in the current code, or that arrives while `busy` is high (other than reset), leaves all outputs unchanged. When several pulses arrive in one cycle, only the highest-priority one is considered, in the order reset, request, release, run, restart, machine-cycle. If that one is not valid in the current code, nothing happens.
- R10: `busack_n` passes through SYNC_STAGES flops. The enables rise exactly SYNC_STAGES+1 clock edges after `busack_n` is first seen low by a waiting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_reset | input | 1 | Pulse: force the CPU into reset and give up the bus |
| cmd_request | input | 1 | Pulse: take ownership of the bus |
| cmd_release | input | 1 | Pulse: give the bus back |
| cmd_run | input | 1 | Pulse: let the CPU run |
| cmd_restart | input | 1 | Pulse: pulse the CPU reset, ownership kept |
| cmd_mcycle | input | 1 | Pulse: hand the bus back for one machine cycle |
| busack_n | input | 1 | Asynchronous active-low bus acknowledge from the CPU |
| tgt_rst_n | output | 1 | Active-low reset to the CPU |
| busreq_n | output | 1 | Active-low bus request to the CPU |
| mreq_n | output | 1 | Memory-request strobe level |
| rd_n | output | 1 | Read strobe level |
| wr_n | output | 1 | Write strobe level |
| ctl_oe | output | 1 | Output enable for the three strobes |
| addr_oe | output | 1 | Output enable for the address bus |
| state_code | output | 2 | Current state code (0..3) |
| busy | output | 1 | A waiting or timed step is in progress |

## Verification
The assertions assume that `busack_n` follows `busreq_n` like a well-behaved CPU would. They also assume that command inputs are single-cycle pulses, sampled only on clock edges. The bench keeps to this by driving every input just after a falling clock edge. An acknowledge responder answers bus-request changes after a programmable delay. In a few phases the responder is switched off and the acknowledge is held or released by hand, so that waiting steps can be stretched and then ended on a known edge.

// File: rtl/tbc_pkg.sv
`timescale 1ns/1ps
package tbc_pkg;

  localparam int NCMD = 6;

  typedef enum logic [1:0] {
    ST_RESET     = 2'd0,
    ST_RESET_OWN = 2'd1,
    ST_RUN       = 2'd2,
    ST_RUN_OWN   = 2'd3
  } tgt_state_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ACKWAIT = 3'd1,
    PH_PULSE   = 3'd2,
    PH_HOLD    = 3'd3,
    PH_REACQ   = 3'd4
  } phase_e;

  // Index of pulse i in the selector maps to code i+1.
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_RESET   = 3'd1,
    CMD_REQUEST = 3'd2,
    CMD_RELEASE = 3'd3,
    CMD_RUN     = 3'd4,
    CMD_RESTART = 3'd5,
    CMD_MCYCLE  = 3'd6
  } cmd_e;

  typedef struct packed {
    tgt_state_e code;
    tgt_state_e pend;
    phase_e     phase;
    logic       restore;
    logic       rst_n;
    logic       breq_n;
    logic       oe;
  } ctl_t;

endpackage

// File: rtl/tbc_sync.sv
`timescale 1ns/1ps
module tbc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RESET_VAL;
        else        pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/tbc_timer.sv
`timescale 1ns/1ps
module tbc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;
  logic         cnt_en;

  assign cnt_en = load || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      if (load) cnt <= load_val;
      else      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/tbc_cmd_sel.sv
`timescale 1ns/1ps
module tbc_cmd_sel
  import tbc_pkg::*;
(
  input  logic [NCMD-1:0] pulses,
  output cmd_e            sel
);

  // Bit 0 wins over bit 1, and so on.
  always_comb begin
    sel = CMD_NONE;
    for (int i = NCMD - 1; i >= 0; i--) begin
      if (pulses[i]) sel = cmd_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/tgt_bus_ctrl.sv
`timescale 1ns/1ps
module tgt_bus_ctrl
  import tbc_pkg::*;
#(
  parameter int RST_PULSE_CYCLES = 1250,
  parameter int BREQ_HOLD_CYCLES = 2,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_reset,
  input  logic       cmd_request,
  input  logic       cmd_release,
  input  logic       cmd_run,
  input  logic       cmd_restart,
  input  logic       cmd_mcycle,
  input  logic       busack_n,
  output logic       tgt_rst_n,
  output logic       busreq_n,
  output logic       mreq_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic       ctl_oe,
  output logic       addr_oe,
  output logic [1:0] state_code,
  output logic       busy
);

  localparam int TMR_MAX = (RST_PULSE_CYCLES > BREQ_HOLD_CYCLES) ?
                           RST_PULSE_CYCLES : BREQ_HOLD_CYCLES;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] PULSE_LOAD = TW'(RST_PULSE_CYCLES - 1);
  localparam logic [TW-1:0] HOLD_LOAD  = TW'(BREQ_HOLD_CYCLES - 1);

  logic          ack_s;
  cmd_e          cmd;
  ctl_t          cur, nxt;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;

  tbc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (busack_n),
    .q     (ack_s)
  );

  tbc_cmd_sel u_sel (
    .pulses ({cmd_mcycle, cmd_restart, cmd_run, cmd_release, cmd_request, cmd_reset}),
    .sel    (cmd)
  );

  tbc_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // Next-state logic
  always_comb begin
    nxt      = cur;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (cmd == CMD_RESET) begin
      nxt.code   = ST_RESET;
      nxt.phase  = PH_IDLE;
      nxt.rst_n  = 1'b0;
      nxt.breq_n = 1'b1;
      nxt.oe     = 1'b0;
    end else begin
      case (cur.phase)
        PH_IDLE: begin
          case (cmd)
            CMD_REQUEST: begin
              if (cur.code == ST_RESET) begin
                nxt.rst_n  = 1'b1;
                nxt.breq_n = 1'b0;
                nxt.pend   = ST_RESET_OWN;
                nxt.phase  = PH_ACKWAIT;
              end else if (cur.code == ST_RUN) begin
                nxt.breq_n = 1'b0;
                nxt.pend   = ST_RUN_OWN;
                nxt.phase  = PH_ACKWAIT;
              end
            end
            CMD_RELEASE: begin
              if (cur.code == ST_RESET_OWN) begin
                nxt.oe     = 1'b0;
                nxt.rst_n  = 1'b0;
                nxt.breq_n = 1'b1;
                nxt.code   = ST_RESET;
              end else if (cur.code == ST_RUN_OWN) begin
                nxt.oe     = 1'b0;
                nxt.breq_n = 1'b1;
                nxt.code   = ST_RUN;
              end
            end
            CMD_RUN: begin
              if (cur.code == ST_RESET) begin
                nxt.rst_n = 1'b1;
                nxt.code  = ST_RUN;
              end else if (cur.code == ST_RESET_OWN) begin
                nxt.oe      = 1'b0;
                nxt.rst_n   = 1'b0;
                nxt.restore = 1'b1;
                nxt.pend    = ST_RUN_OWN;
                nxt.phase   = PH_PULSE;
                tmr_load    = 1'b1;
                tmr_val     = PULSE_LOAD;
              end
            end
            CMD_RESTART: begin
              if (cur.code == ST_RUN || cur.code == ST_RUN_OWN) begin
                nxt.rst_n   = 1'b0;
                nxt.restore = cur.oe;
                nxt.pend    = cur.code;
                nxt.phase   = PH_PULSE;
                tmr_load    = 1'b1;
                tmr_val     = PULSE_LOAD;
              end
            end
            CMD_MCYCLE: begin
              if (cur.code == ST_RUN_OWN) begin
                nxt.oe     = 1'b0;
                nxt.breq_n = 1'b1;
                nxt.phase  = PH_HOLD;
                tmr_load   = 1'b1;
                tmr_val    = HOLD_LOAD;
              end
            end
            default: ;
          endcase
        end
        PH_ACKWAIT: begin
          if (!ack_s) begin
            nxt.oe    = 1'b1;
            nxt.code  = cur.pend;
            nxt.phase = PH_IDLE;
          end
        end
        PH_PULSE: begin
          if (tmr_done) begin
            nxt.rst_n = 1'b1;
            nxt.oe    = cur.restore;
            nxt.code  = cur.pend;
            nxt.phase = PH_IDLE;
          end
        end
        PH_HOLD: begin
          if (tmr_done) begin
            nxt.breq_n = 1'b0;
            nxt.phase  = PH_REACQ;
          end
        end
        PH_REACQ: begin
          if (!ack_s) begin
            nxt.oe    = 1'b1;
            nxt.phase = PH_IDLE;
          end
        end
        default: nxt.phase = PH_IDLE;
      endcase
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '{code: ST_RESET, pend: ST_RESET, phase: PH_IDLE, restore: 1'b0,
               rst_n: 1'b0, breq_n: 1'b1, oe: 1'b0};
    end else begin
      cur <= nxt;
    end
  end

  assign tgt_rst_n  = cur.rst_n;
  assign busreq_n   = cur.breq_n;
  assign addr_oe    = cur.oe;
  assign ctl_oe     = cur.oe;
  assign mreq_n     = cur.oe;
  assign rd_n       = cur.oe;
  assign wr_n       = cur.oe;
  assign state_code = cur.code;
  assign busy       = (cur.phase != PH_IDLE);

  // Run-length counters used only by the checks below
  localparam int CW = $clog2(TMR_MAX + 2);
  localparam logic [CW-1:0] RUN_SAT = {CW{1'b1}};
  logic [CW-1:0] low_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      hi_run  <= '0;
    end else begin
      if (tgt_rst_n)            low_run <= '0;
      else if (low_run != RUN_SAT) low_run <= low_run + 1'b1;
      if (!busreq_n)            hi_run <= '0;
      else if (hi_run != RUN_SAT)  hi_run <= hi_run + 1'b1;
    end
  end

  // R2
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (state_code == 2'd0) && !tgt_rst_n && busreq_n && !addr_oe && !busy);

  // R3
  own_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> !busreq_n);

  // R10
  ack_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> $past(!ack_s));

  // R6
  rst_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_rst_n) && $past(cur.phase == PH_PULSE)) |-> (low_run == CW'(RST_PULSE_CYCLES)));

  // R7
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busreq_n) && $past(cur.phase == PH_HOLD)) |-> (hi_run == CW'(BREQ_HOLD_CYCLES)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_reset && !cmd_request && !cmd_release && !cmd_run && !cmd_restart && !cmd_mcycle)
    |=> $stable(state_code));

endmodule

// File: tb/tgt_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module tgt_bus_ctrl_tb_top;

  localparam int P = 40;
  localparam int H = 2;
  localparam int S = 2;
  localparam int I_RESET = 0, I_REQ = 1, I_REL = 2, I_RUN = 3, I_RESTART = 4, I_MC = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [5:0] cmdv;
  logic       busack_n;
  logic       tgt_rst_n, busreq_n, mreq_n, rd_n, wr_n, ctl_oe, addr_oe, busy;
  logic [1:0] state_code;

  tgt_bus_ctrl #(.RST_PULSE_CYCLES(P), .BREQ_HOLD_CYCLES(H), .SYNC_STAGES(S)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_reset(cmdv[I_RESET]), .cmd_request(cmdv[I_REQ]), .cmd_release(cmdv[I_REL]),
    .cmd_run(cmdv[I_RUN]), .cmd_restart(cmdv[I_RESTART]), .cmd_mcycle(cmdv[I_MC]),
    .busack_n(busack_n), .tgt_rst_n(tgt_rst_n), .busreq_n(busreq_n),
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe), .addr_oe(addr_oe),
    .state_code(state_code), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: mode numbers 0 idle, 1 wait ack, 2 reset pulse,
  // 3 request hold-off, 4 wait ack again.
  int    m_st, m_mode, m_pend, m_el, m_rest, m_rst, m_breq, m_oe;
  int    ack_q[$];
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mode = 0; m_pend = 0; m_el = 0; m_rest = 0;
      m_rst = 0; m_breq = 1; m_oe = 0; m_tag = "R1";
      ack_q = {};
      for (int k = 0; k < S; k++) ack_q.push_back(1);
    end else begin
      int seen_ack;
      int pick;
      seen_ack = ack_q[0];
      pick = -1;
      for (int k = 5; k >= 0; k--) if (cmdv[k]) pick = k;
      if (pick == I_RESET) begin
        m_st = 0; m_mode = 0; m_rst = 0; m_breq = 1; m_oe = 0; m_tag = "R2";
      end else if (m_mode == 0) begin
        if (pick == I_REQ && (m_st == 0 || m_st == 2)) begin
          if (m_st == 0) m_rst = 1;
          m_breq = 0; m_pend = m_st + 1; m_mode = 1; m_tag = "R3";
        end else if (pick == I_REL && (m_st == 1 || m_st == 3)) begin
          m_oe = 0; m_breq = 1;
          if (m_st == 1) m_rst = 0;
          m_st = m_st - 1; m_tag = "R4";
        end else if (pick == I_RUN && m_st == 0) begin
          m_rst = 1; m_st = 2; m_tag = "R5";
        end else if (pick == I_RUN && m_st == 1) begin
          m_oe = 0; m_rst = 0; m_el = 0; m_rest = 1; m_pend = 3; m_mode = 2; m_tag = "R5";
        end else if (pick == I_RESTART && m_st >= 2) begin
          m_rst = 0; m_el = 0; m_rest = m_oe; m_pend = m_st; m_mode = 2; m_tag = "R6";
        end else if (pick == I_MC && m_st == 3) begin
          m_oe = 0; m_breq = 1; m_el = 0; m_mode = 3; m_tag = "R7";
        end else if (pick >= 0) begin
          m_tag = "R9";
        end
      end else if (m_mode == 1) begin
        if (seen_ack == 0) begin m_oe = 1; m_st = m_pend; m_mode = 0; end
      end else if (m_mode == 2) begin
        m_el++;
        if (m_el == P) begin m_rst = 1; m_oe = m_rest; m_st = m_pend; m_mode = 0; end
      end else if (m_mode == 3) begin
        m_el++;
        if (m_el == H) begin m_breq = 0; m_mode = 4; end
      end else begin
        if (seen_ack == 0) begin m_oe = 1; m_mode = 0; end
      end
      void'(ack_q.pop_front());
      ack_q.push_back(int'(busack_n));
    end
  end

  function automatic int dut_vec();
    return int'({state_code, busy, tgt_rst_n, busreq_n, addr_oe, ctl_oe, mreq_n, rd_n, wr_n});
  endfunction

  function automatic int model_vec();
    logic [1:0] s;
    logic b, r, q, o;
    s = 2'(m_st); b = (m_mode != 0); r = m_rst[0]; q = m_breq[0]; o = m_oe[0];
    return int'({s, b, r, q, o, o, o, o, o});
  endfunction

  // Acknowledge responder
  bit ack_auto = 1;
  int ack_delay = 2;
  int ack_cnt = 0;

  task automatic tick();
    @(negedge clk);
    chk(dut_vec() == model_vec(), {m_tag, " per-cycle model compare"}, dut_vec(), model_vec());
    if (ack_auto) begin
      if (busack_n != busreq_n) begin
        if (ack_cnt >= ack_delay) begin busack_n = busreq_n; ack_cnt = 0; end
        else ack_cnt++;
      end else ack_cnt = 0;
    end
  endtask

  task automatic issue(int idx);
    cmdv[idx] = 1'b1;
    tick();
    cmdv = '0;
  endtask

  task automatic issue2(int a, int b);
    cmdv[a] = 1'b1;
    cmdv[b] = 1'b1;
    tick();
    cmdv = '0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin tick(); g++; end
  endtask

  task automatic settle();
    repeat (8) tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cmdv = '0; busack_n = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(state_code == 2'd0, "R1 code", state_code, 0);
    chk(!tgt_rst_n && busreq_n && !addr_oe && !ctl_oe && !busy, "R1 outputs",
        dut_vec(), 0);

    // R3 request from code 0
    issue(I_REQ);
    chk(!busreq_n && tgt_rst_n && busy && !addr_oe, "R3 request from 0 first cycle", dut_vec(), 0);
    wait_idle();
    chk(state_code == 2'd1 && addr_oe, "R3 owned in code 1", state_code, 1);
    chk(mreq_n && rd_n && wr_n && ctl_oe, "R8 strobes high while driven", mreq_n, 1);

    // R4 release from code 1
    issue(I_REL);
    chk(state_code == 2'd0 && !tgt_rst_n && busreq_n && !addr_oe, "R4 release from 1", state_code, 0);
    chk(!mreq_n && !rd_n && !wr_n && !ctl_oe, "R8 strobes 0 while released", mreq_n, 0);
    settle();

    // R5 run from code 0
    issue(I_RUN);
    chk(state_code == 2'd2 && tgt_rst_n && !busy, "R5 run from 0", state_code, 2);

    // R9 invalid commands in code 2
    issue(I_REL); issue(I_RUN); issue(I_MC);
    tick();
    chk(state_code == 2'd2 && !busy && !addr_oe && busreq_n && tgt_rst_n, "R9 invalid in code 2", state_code, 2);

    // R3 request from code 2
    issue(I_REQ);
    chk(tgt_rst_n && !busreq_n && busy, "R3 request from 2 keeps reset high", tgt_rst_n, 1);
    wait_idle();
    chk(state_code == 2'd3 && addr_oe, "R3 owned in code 3", state_code, 3);

    // R6 restart in code 3
    issue(I_RESTART);
    chk(addr_oe == 1'b1, "R6 enables kept during restart", addr_oe, 1);
    n = 0;
    while (!tgt_rst_n && n < 5000) begin n++; tick(); end
    chk(n == P, "R6 restart pulse length in code 3", n, P);
    chk(state_code == 2'd3 && addr_oe && !busy, "R6 code 3 kept", state_code, 3);

    // R7 machine cycle
    issue(I_MC);
    chk(!addr_oe && busy, "R7 enables dropped", addr_oe, 0);
    n = 0;
    while (busreq_n && n < 5000) begin n++; tick(); end
    chk(n == H, "R7 request high length", n, H);
    wait_idle();
    chk(state_code == 2'd3 && addr_oe, "R7 bus back after machine cycle", state_code, 3);
    settle();
    ack_delay = 5;
    issue(I_MC);
    wait_idle();
    chk(state_code == 2'd3 && addr_oe, "R7 machine cycle slow ack", state_code, 3);
    settle();
    ack_delay = 0;
    issue(I_MC);
    wait_idle();
    chk(state_code == 2'd3 && addr_oe, "R7 machine cycle fast ack", state_code, 3);
    settle();
    ack_delay = 2;

    // R9 run invalid in code 3
    issue(I_RUN);
    tick();
    chk(state_code == 2'd3 && !busy && tgt_rst_n, "R9 run ignored in code 3", state_code, 3);

    // R4 release from code 3, then R6 restart in code 2
    issue(I_REL);
    chk(state_code == 2'd2 && tgt_rst_n && busreq_n && !addr_oe, "R4 release from 3", state_code, 2);
    settle();
    issue(I_RESTART);
    n = 0;
    while (!tgt_rst_n && n < 5000) begin n++; chk(!addr_oe, "R6 enables stay off in code 2", addr_oe, 0); tick(); end
    chk(n == P, "R6 restart pulse length in code 2", n, P);
    chk(state_code == 2'd2, "R6 code 2 kept", state_code, 2);

    // R2 reset command from code 2
    issue(I_RESET);
    chk(state_code == 2'd0 && !tgt_rst_n && busreq_n, "R2 reset from 2", state_code, 0);
    settle();

    // R5 run from code 1
    issue(I_REQ);
    wait_idle();
    issue(I_RUN);
    chk(!addr_oe && !tgt_rst_n && busy, "R5 run from 1 floats and pulses", addr_oe, 0);
    n = 0;
    while (!tgt_rst_n && n < 5000) begin n++; tick(); end
    chk(n == P, "R5 run-from-1 pulse length", n, P);
    chk(state_code == 2'd3 && addr_oe, "R5 run from 1 ends in 3", state_code, 3);

    // R10 synchroniser latency, R9 busy ignore
    issue(I_REL);
    settle();
    ack_auto = 0;
    issue(I_REQ);
    repeat (5) tick();
    chk(busy && !addr_oe && state_code == 2'd2, "R10 wait holds without ack", state_code, 2);
    issue(I_REL); issue(I_RUN); issue(I_RESTART);
    chk(busy && state_code == 2'd2 && tgt_rst_n && !busreq_n, "R9 commands ignored while busy", state_code, 2);
    busack_n = 1'b0;
    n = 0;
    while (!addr_oe && n < 50) begin n++; tick(); end
    chk(n == S + 1, "R10 ack to enable latency", n, S + 1);
    chk(state_code == 2'd3, "R10 code after ack", state_code, 3);

    // R2 reset during a wait
    issue(I_REL);
    busack_n = 1'b1;
    settle();
    issue(I_REQ);
    repeat (3) tick();
    issue(I_RESET);
    chk(state_code == 2'd0 && !busy && busreq_n && !tgt_rst_n, "R2 reset aborts wait", state_code, 0);
    ack_auto = 1;
    settle();

    // R9 priority among simultaneous pulses
    issue2(I_RESET, I_RUN);
    chk(state_code == 2'd0 && !tgt_rst_n, "R9 reset beats run", state_code, 0);
    issue2(I_REQ, I_RUN);
    chk(busy && !busreq_n, "R9 request beats run", busreq_n, 0);
    wait_idle();
    chk(state_code == 2'd1, "R9 request result", state_code, 1);
    issue2(I_REL, I_RUN);
    chk(state_code == 2'd0 && !busy, "R9 release beats run", state_code, 0);
    settle();
    issue(I_RUN);
    issue2(I_REL, I_RESTART);
    tick();
    chk(state_code == 2'd2 && tgt_rst_n && !busy, "R9 invalid top pulse masks restart", state_code, 2);

    repeat (4) tick();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule